// File: doc/BRIEF.md
# Wrapped Key Decrypt Sequencer

This block runs a single block-decrypt operation whose 256-bit key arrives wrapped inside a 512-bit handle. A one-cycle `start` pulse captures the handle, a 128-bit data block and the caller's 2-bit privilege level. The sequencer checks the handle's control bits, reserved bits and key-type field. A handle that fails any check ends the operation at once, and no external unit is contacted.

A handle that passes is sent to an external unwrap/authenticate unit over a valid/ready request channel. The unit answers on a valid/ready response channel with the unwrapped key and an authenticity bit. If the handle is authentic, the key and data go to an external 256-bit block-decrypt unit over a second pair of channels, and the result replaces the held data block. If the handle is not authentic, the data block is left as it was.

Every completed operation ends with a single-cycle `done`. On that cycle `data_out` holds the data block. `zf` is 0 when the data was decrypted and 1 on any failure. The other five arithmetic flags are always reported as 0. The unwrapped key is held only while it is needed and appears on the decrypt key port only.

Top module: `wkey_dec_seq`

## Requirements
- R1: A handle with any bit set under the reserved mask (default: bits 27:3) is illegal. The result is `zf`=1 and no unwrap request.
- R2: A handle with bit 0 set is illegal when `cpl` is nonzero. It is legal at `cpl`=0 if all other checks pass.
- R3: A handle with bit 2 set is illegal.
- R4: The key-type field (default bits 31:28) must equal 4'h2. Any other value makes the handle illegal.
- R5: For an illegal handle, no unwrap request and no decrypt request is issued. `done` comes with `zf`=1 and `data_out` equal to the captured data.
- R6: When the unwrap response has `auth`=0, no decrypt request is issued. The next cycle carries `done` with `zf`=1 and the data unchanged.
- R7: When the unwrap response has `auth`=1, the captured data and the unwrapped key go to the decrypt unit. `data_out` takes the decrypt result and `zf`=0 on `done`.
- R8: `arith_flags` (order {OF,SF,AF,PF,CF}) reads 0 on every `done`, whether the operation succeeded or failed.
- R9: `done` is high for exactly one cycle per operation, and `data_out`, `zf` and `arith_flags` are valid on that cycle. After reset, `done`, `zf` and both request valids are 0.
- R10: `dec_key` is all zeros whenever `dec_req_valid` is low. The unwrapped key reaches no other output.
- R11: A `start` received while an operation is in progress is ignored. The captured handle, data and privilege level do not change.
- R12: Both request valids stay high until accepted by their ready. Responses are taken only while the matching `*_rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| handle_in | input | 512 | Wrapped key handle |
| data_in | input | 128 | Data block to decrypt |
| cpl | input | 2 | Current privilege level |
| unwrap_req_valid | output | 1 | Unwrap request valid |
| unwrap_req_ready | input | 1 | Unwrap unit accepts request |
| unwrap_handle | output | 512 | Handle sent for unwrapping |
| unwrap_rsp_valid | input | 1 | Unwrap response valid |
| unwrap_rsp_ready | output | 1 | Sequencer accepts unwrap response |
| unwrap_key | input | 256 | Unwrapped key |
| unwrap_auth | input | 1 | Handle authentic |
| dec_req_valid | output | 1 | Decrypt request valid |
| dec_req_ready | input | 1 | Decrypt unit accepts request |
| dec_key | output | 256 | Key for decrypt unit (zero when idle) |
| dec_data | output | 128 | Data block sent for decryption |
| dec_rsp_valid | input | 1 | Decrypt result valid |
| dec_rsp_ready | output | 1 | Sequencer accepts decrypt result |
| dec_result | input | 128 | Decrypted block |
| done | output | 1 | One-cycle completion strobe |
| data_out | output | 128 | Data block after the operation |
| zf | output | 1 | 1 on failure, 0 on success |
| arith_flags | output | 5 | {OF,SF,AF,PF,CF}, cleared on completion |

## Verification
The bench targets the single-cause rejections: one reserved bit, bit 2, a wrong key type, and bit 0 at nonzero privilege, alongside bit 0 at privilege 0, which must pass. A design that merged these checks wrongly would either decrypt with a forbidden handle or reject a good one. An authentication failure must leave the data untouched. A design that wrote back regardless would show the decrypt result with `zf`=1, or issue a stray decrypt request.

Stalled ready signals and a second `start` sent in mid-operation cover two more faults. A design that dropped a valid under back-pressure would stall or issue duplicate requests. A design that re-captured inputs while busy would return a result for the wrong data. A monitor also watches `dec_key` for any key value outside an active decrypt request.

// File: rtl/wkd_pkg.sv
package wkd_pkg;

    localparam int HANDLE_W = 512;
    localparam int DATA_W   = 128;
    localparam int KEY_W    = 256;
    localparam int CPL_W    = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_UNWRAP_WAIT,
        ST_DECRYPT_WAIT,
        ST_DONE
    } wkd_state_e;

    typedef struct packed {
        logic zf;
        logic of_f;
        logic sf;
        logic af;
        logic pf;
        logic cf;
    } wkd_flags_t;

    function automatic wkd_flags_t outcome_flags(input logic failed);
        wkd_flags_t f;
        f      = '0;
        f.zf   = failed;
        return f;
    endfunction

endpackage

// File: rtl/wkd_legal.sv
module wkd_legal
    import wkd_pkg::*;
#(
    parameter logic [HANDLE_W-1:0] RSVD_MASK = HANDLE_W'(32'h0FFF_FFF8),
    parameter int                  KT_LSB    = 28,
    parameter int                  KT_W      = 4,
    parameter logic [KT_W-1:0]     KT_AES256 = 4'h2
) (
    input  logic [HANDLE_W-1:0] handle,
    input  logic [CPL_W-1:0]    cpl,
    output logic                legal
);
    localparam int KT_MSB = KT_LSB + KT_W - 1;

    logic rsvd_hit;
    logic priv_hit;
    logic bit2_hit;
    logic type_bad;

    always_comb begin
        rsvd_hit = |(handle & RSVD_MASK);
        priv_hit = handle[0] && (cpl != '0);
        bit2_hit = handle[2];
        type_bad = handle[KT_MSB:KT_LSB] != KT_AES256;
        legal    = !(rsvd_hit || priv_hit || bit2_hit || type_bad);
    end
endmodule

// File: rtl/wkd_ctrl.sv
module wkd_ctrl
    import wkd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic legal,
    input  logic unwrap_req_ready,
    input  logic unwrap_rsp_valid,
    input  logic unwrap_auth,
    input  logic dec_req_ready,
    input  logic dec_rsp_valid,
    output logic load_in,
    output logic load_key,
    output logic load_result,
    output logic clr_key,
    output logic finish,
    output logic fail,
    output logic unwrap_req_valid,
    output logic unwrap_rsp_ready,
    output logic dec_req_valid,
    output logic dec_rsp_ready,
    output logic done,
    output logic busy
);
    wkd_state_e state_q, state_n;
    logic       pend_q, pend_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
        end
    end

    always_comb begin
        state_n     = state_q;
        pend_n      = pend_q;
        load_in     = 1'b0;
        load_key    = 1'b0;
        load_result = 1'b0;
        clr_key     = 1'b0;
        finish      = 1'b0;
        fail        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load_in = 1'b1;
                    state_n = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (legal) begin
                    state_n = ST_UNWRAP_WAIT;
                    pend_n  = 1'b1;
                end else begin
                    state_n = ST_DONE;
                    finish  = 1'b1;
                    fail    = 1'b1;
                end
            end
            ST_UNWRAP_WAIT: begin
                if (pend_q) begin
                    if (unwrap_req_ready) pend_n = 1'b0;
                end else if (unwrap_rsp_valid) begin
                    if (unwrap_auth) begin
                        load_key = 1'b1;
                        pend_n   = 1'b1;
                        state_n  = ST_DECRYPT_WAIT;
                    end else begin
                        finish  = 1'b1;
                        fail    = 1'b1;
                        state_n = ST_DONE;
                    end
                end
            end
            ST_DECRYPT_WAIT: begin
                if (pend_q) begin
                    if (dec_req_ready) pend_n = 1'b0;
                end else if (dec_rsp_valid) begin
                    load_result = 1'b1;
                    finish      = 1'b1;
                    state_n     = ST_DONE;
                end
            end
            ST_DONE: begin
                clr_key = 1'b1;
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign unwrap_req_valid = (state_q == ST_UNWRAP_WAIT) && pend_q;
    assign unwrap_rsp_ready = (state_q == ST_UNWRAP_WAIT) && !pend_q;
    assign dec_req_valid    = (state_q == ST_DECRYPT_WAIT) && pend_q;
    assign dec_rsp_ready    = (state_q == ST_DECRYPT_WAIT) && !pend_q;
    assign done             = (state_q == ST_DONE);
    assign busy             = (state_q != ST_IDLE);
endmodule

// File: rtl/wkey_dec_seq.sv
module wkey_dec_seq
    import wkd_pkg::*;
#(
    parameter logic [HANDLE_W-1:0] RSVD_MASK = HANDLE_W'(32'h0FFF_FFF8),
    parameter int                  KT_LSB    = 28,
    parameter int                  KT_W      = 4,
    parameter logic [KT_W-1:0]     KT_AES256 = 4'h2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [HANDLE_W-1:0] handle_in,
    input  logic [DATA_W-1:0]   data_in,
    input  logic [CPL_W-1:0]    cpl,
    output logic                unwrap_req_valid,
    input  logic                unwrap_req_ready,
    output logic [HANDLE_W-1:0] unwrap_handle,
    input  logic                unwrap_rsp_valid,
    output logic                unwrap_rsp_ready,
    input  logic [KEY_W-1:0]    unwrap_key,
    input  logic                unwrap_auth,
    output logic                dec_req_valid,
    input  logic                dec_req_ready,
    output logic [KEY_W-1:0]    dec_key,
    output logic [DATA_W-1:0]   dec_data,
    input  logic                dec_rsp_valid,
    output logic                dec_rsp_ready,
    input  logic [DATA_W-1:0]   dec_result,
    output logic                done,
    output logic [DATA_W-1:0]   data_out,
    output logic                zf,
    output logic [4:0]          arith_flags
);
    logic [HANDLE_W-1:0] handle_q;
    logic [DATA_W-1:0]   data_q;
    logic [CPL_W-1:0]    cpl_q;
    logic [KEY_W-1:0]    key_q;
    wkd_flags_t          flags_q;

    logic legal, busy;
    logic load_in, load_key, load_result, clr_key, finish, fail;

    wkd_legal #(
        .RSVD_MASK (RSVD_MASK),
        .KT_LSB    (KT_LSB),
        .KT_W      (KT_W),
        .KT_AES256 (KT_AES256)
    ) u_legal (
        .handle (handle_q),
        .cpl    (cpl_q),
        .legal  (legal)
    );

    wkd_ctrl u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .start            (start),
        .legal            (legal),
        .unwrap_req_ready (unwrap_req_ready),
        .unwrap_rsp_valid (unwrap_rsp_valid),
        .unwrap_auth      (unwrap_auth),
        .dec_req_ready    (dec_req_ready),
        .dec_rsp_valid    (dec_rsp_valid),
        .load_in          (load_in),
        .load_key         (load_key),
        .load_result      (load_result),
        .clr_key          (clr_key),
        .finish           (finish),
        .fail             (fail),
        .unwrap_req_valid (unwrap_req_valid),
        .unwrap_rsp_ready (unwrap_rsp_ready),
        .dec_req_valid    (dec_req_valid),
        .dec_rsp_ready    (dec_rsp_ready),
        .done             (done),
        .busy             (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            handle_q <= '0;
            data_q   <= '0;
            cpl_q    <= '0;
            key_q    <= '0;
            flags_q  <= '0;
        end else begin
            if (load_in) begin
                handle_q <= handle_in;
                data_q   <= data_in;
                cpl_q    <= cpl;
            end else if (load_result) begin
                data_q <= dec_result;
            end
            if (load_key)     key_q <= unwrap_key;
            else if (clr_key) key_q <= '0;
            if (finish)       flags_q <= outcome_flags(fail);
        end
    end

    assign unwrap_handle = handle_q;
    assign dec_data      = data_q;
    assign dec_key       = dec_req_valid ? key_q : '0;
    assign data_out      = data_q;
    assign zf            = flags_q.zf;
    assign arith_flags   = {flags_q.of_f, flags_q.sf, flags_q.af, flags_q.pf, flags_q.cf};
endmodule

// File: rtl/wkd_chk.sv
module wkd_chk
    import wkd_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                busy,
    input logic                legal,
    input logic                unwrap_req_valid,
    input logic                unwrap_req_ready,
    input logic [HANDLE_W-1:0] unwrap_handle,
    input logic                unwrap_rsp_valid,
    input logic                unwrap_rsp_ready,
    input logic                unwrap_auth,
    input logic                dec_req_valid,
    input logic                dec_req_ready,
    input logic [KEY_W-1:0]    dec_key,
    input logic                dec_rsp_valid,
    input logic                dec_rsp_ready,
    input logic [DATA_W-1:0]   dec_result,
    input logic                done,
    input logic [DATA_W-1:0]   data_out,
    input logic                zf,
    input logic [4:0]          arith_flags
);
    // R5
    illegal_no_unwrap_chk: assert property (@(posedge clk) disable iff (rst)
        unwrap_req_valid |-> legal);

    // R6
    auth_fail_done_chk: assert property (@(posedge clk) disable iff (rst)
        (unwrap_rsp_valid && unwrap_rsp_ready && !unwrap_auth) |=> (done && zf && !dec_req_valid));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(dec_rsp_valid && dec_rsp_ready) && !(start && !busy) |=> $stable(data_out));

    // R7
    result_write_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_rsp_valid && dec_rsp_ready) |=> (done && !zf && data_out == $past(dec_result)));

    // R8
    arith_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (arith_flags == 5'd0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    key_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_req_valid |-> (dec_key == '0));

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(unwrap_handle));

    // R12
    unwrap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (unwrap_req_valid && !unwrap_req_ready) |=> unwrap_req_valid);

    // R12
    dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_req_valid && !dec_req_ready) |=> dec_req_valid);
endmodule

bind wkey_dec_seq wkd_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .start            (start),
    .busy             (busy),
    .legal            (legal),
    .unwrap_req_valid (unwrap_req_valid),
    .unwrap_req_ready (unwrap_req_ready),
    .unwrap_handle    (unwrap_handle),
    .unwrap_rsp_valid (unwrap_rsp_valid),
    .unwrap_rsp_ready (unwrap_rsp_ready),
    .unwrap_auth      (unwrap_auth),
    .dec_req_valid    (dec_req_valid),
    .dec_req_ready    (dec_req_ready),
    .dec_key          (dec_key),
    .dec_rsp_valid    (dec_rsp_valid),
    .dec_rsp_ready    (dec_rsp_ready),
    .dec_result       (dec_result),
    .done             (done),
    .data_out         (data_out),
    .zf               (zf),
    .arith_flags      (arith_flags)
);

// File: tb/wkey_dec_seq_bench.sv
`timescale 1ns/1ps
module wkey_dec_seq_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [511:0] handle_in;
    logic [127:0] data_in;
    logic [1:0]   cpl;
    logic         unwrap_req_valid, unwrap_req_ready, unwrap_rsp_valid, unwrap_rsp_ready, unwrap_auth;
    logic [511:0] unwrap_handle;
    logic [255:0] unwrap_key;
    logic         dec_req_valid, dec_req_ready, dec_rsp_valid, dec_rsp_ready;
    logic [255:0] dec_key;
    logic [127:0] dec_data, dec_result, data_out;
    logic         done, zf;
    logic [4:0]   arith_flags;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    wkey_dec_seq u_wkey_dec_seq (.*);

    // ---------------- external unit stubs ----------------
    logic        rdy_always;
    logic [7:0]  cyc;
    logic        u_busy, d_busy;
    logic [1:0]  u_cnt, d_cnt;
    logic [511:0] u_hnd;
    logic [255:0] d_key;
    logic [127:0] d_dat;
    int          unwrap_reqs, dec_reqs, key_leaks;

    assign unwrap_req_ready = !u_busy && (rdy_always || cyc[1]);
    assign unwrap_rsp_valid = u_busy && (u_cnt == 2'd0);
    assign unwrap_key       = unwrap_rsp_valid ? u_hnd[511:256] : '0;
    assign unwrap_auth      = ~u_hnd[1];
    assign dec_req_ready    = !d_busy && (rdy_always || cyc[1]);
    assign dec_rsp_valid    = d_busy && (d_cnt == 2'd0);
    assign dec_result       = d_dat ^ d_key[127:0] ^ d_key[255:128];

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0; u_busy <= 1'b0; d_busy <= 1'b0; u_cnt <= '0; d_cnt <= '0;
            u_hnd <= '0; d_key <= '0; d_dat <= '0;
            unwrap_reqs <= 0; dec_reqs <= 0;
        end else begin
            cyc <= cyc + 8'd1;
            if (unwrap_req_valid && unwrap_req_ready) begin
                u_busy <= 1'b1; u_cnt <= 2'd2; u_hnd <= unwrap_handle;
                unwrap_reqs <= unwrap_reqs + 1;
            end else if (u_busy && u_cnt != 2'd0) u_cnt <= u_cnt - 2'd1;
            else if (unwrap_rsp_valid && unwrap_rsp_ready) u_busy <= 1'b0;
            if (dec_req_valid && dec_req_ready) begin
                d_busy <= 1'b1; d_cnt <= 2'd3; d_key <= dec_key; d_dat <= dec_data;
                dec_reqs <= dec_reqs + 1;
            end else if (d_busy && d_cnt != 2'd0) d_cnt <= d_cnt - 2'd1;
            else if (dec_rsp_valid && dec_rsp_ready) d_busy <= 1'b0;
        end
    end

    // R10 monitor: key must be zero outside a decrypt request
    initial key_leaks = 0;
    always @(negedge clk) if (!rst && !dec_req_valid && dec_key != '0) key_leaks++;

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [511:0] mk_handle(input logic [2:0] ctl, input logic [3:0] kt,
                                               input logic rsvd, input int idx);
        logic [511:0] h;
        h           = '0;
        h[511:384]  = {4{32'hC0DE_0000 | 32'(idx)}};
        h[383:256]  = {4{32'h5A17_0000 | 32'(idx * 3)}};
        h[255:32]   = {7{32'h1234_0000 | 32'(idx)}};
        h[31:28]    = kt;
        h[8]        = rsvd;
        h[2:0]      = ctl;
        return h;
    endfunction

    function automatic logic [127:0] model_dec(input logic [511:0] h, input logic [127:0] d);
        return d ^ h[383:256] ^ h[511:384];
    endfunction

    logic [127:0] got_data;
    logic         got_zf, got_done_after;
    logic [4:0]   got_ar;

    task automatic run_op(input logic [511:0] h, input logic [127:0] d, input logic [1:0] c,
                          input logic inject);
        int cnt;
        @(negedge clk);
        handle_in = h; data_in = d; cpl = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 200) begin
            @(negedge clk);
            cnt++;
            if (inject && cnt == 3) begin
                handle_in = ~h; data_in = ~d; cpl = 2'd3; start = 1'b1;
            end else start = 1'b0;
        end
        start = 1'b0;
        if (cnt >= 200) chk(1'b0, "R9", "done timeout", 128'(cnt), 128'd0);
        got_data = data_out; got_zf = zf; got_ar = arith_flags;
        @(negedge clk);
        got_done_after = done;
    endtask

    // table: {cpl[1:0], ctl[2:0], kt[3:0], rsvd, exp_zf, req[3:0]}
    localparam int NV = 8;
    localparam logic [14:0] VEC [NV] = '{
        {2'd0, 3'b000, 4'h2, 1'b0, 1'b0, 4'd7},   // R7 clean success
        {2'd3, 3'b001, 4'h2, 1'b0, 1'b1, 4'd2},   // R2 bit0 at cpl 3
        {2'd0, 3'b001, 4'h2, 1'b0, 1'b0, 4'd2},   // R2 bit0 at cpl 0 allowed
        {2'd0, 3'b100, 4'h2, 1'b0, 1'b1, 4'd3},   // R3 bit2
        {2'd0, 3'b000, 4'h3, 1'b0, 1'b1, 4'd4},   // R4 wrong key type
        {2'd0, 3'b000, 4'h2, 1'b1, 1'b1, 4'd1},   // R1 reserved bit 8
        {2'd0, 3'b010, 4'h2, 1'b0, 1'b1, 4'd6},   // R6 not authentic
        {2'd1, 3'b000, 4'h2, 1'b0, 1'b0, 4'd7}    // R7 success at cpl 1
    };

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; handle_in = '0; data_in = '0; cpl = '0; rdy_always = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(!done, "R9", "done after reset", 128'(done), 128'd0);
        chk(!zf, "R9", "zf after reset", 128'(zf), 128'd0);
        chk(!unwrap_req_valid && !dec_req_valid, "R9", "request valids after reset",
            128'({unwrap_req_valid, dec_req_valid}), 128'd0);

        for (int i = 0; i < NV; i++) begin
            logic [511:0] h;
            logic [127:0] d, exp_d;
            logic         ezf, legal_path;
            int           ur0, dr0;
            string        rq;
            h   = mk_handle(VEC[i][12:10], VEC[i][9:6], VEC[i][5], i);
            d   = {4{32'h0BAD_F00D ^ 32'(i * 32'h0101_0101)}};
            ezf = VEC[i][4];
            rq  = $sformatf("R%0d", VEC[i][3:0]);
            exp_d = ezf ? d : model_dec(h, d);
            legal_path = !ezf || (VEC[i][3:0] == 4'd6);
            ur0 = unwrap_reqs; dr0 = dec_reqs;
            run_op(h, d, VEC[i][14:13], 1'b0);
            chk(got_zf == ezf, rq, "zf", 128'(got_zf), 128'(ezf));
            chk(got_data == exp_d, rq, "data_out", got_data, exp_d);
            // R8 arithmetic flags cleared
            chk(got_ar == 5'd0, "R8", "arith_flags", 128'(got_ar), 128'd0);
            // R9 single-cycle done
            chk(!got_done_after, "R9", "done width", 128'(got_done_after), 128'd0);
            // R5 / R6 request counts
            chk((unwrap_reqs - ur0) == (legal_path ? 1 : 0), legal_path ? rq : "R5",
                "unwrap requests", 128'(unwrap_reqs - ur0), 128'(legal_path ? 1 : 0));
            chk((dec_reqs - dr0) == (ezf ? 0 : 1), ezf ? "R5" : "R7", "decrypt requests",
                128'(dec_reqs - dr0), 128'(ezf ? 0 : 1));
        end

        // R12 back-pressure on both request channels
        begin
            logic [511:0] h; logic [127:0] d; int ur0, dr0;
            rdy_always = 1'b0;
            h = mk_handle(3'b000, 4'h2, 1'b0, 11); d = 128'hFACE_0000_1111_2222_3333_4444_5555_6666;
            ur0 = unwrap_reqs; dr0 = dec_reqs;
            run_op(h, d, 2'd0, 1'b0);
            chk(got_data == model_dec(h, d) && !got_zf, "R12", "stalled success data",
                got_data, model_dec(h, d));
            chk(unwrap_reqs - ur0 == 1 && dec_reqs - dr0 == 1, "R12", "single request each",
                128'({unwrap_reqs - ur0, dec_reqs - dr0}), 128'({32'd1, 32'd1}));

            // R11 start during operation ignored
            h = mk_handle(3'b000, 4'h2, 1'b0, 12); d = 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978;
            ur0 = unwrap_reqs;
            run_op(h, d, 2'd0, 1'b1);
            chk(got_data == model_dec(h, d) && !got_zf, "R11", "result after mid-run start",
                got_data, model_dec(h, d));
            chk(unwrap_reqs - ur0 == 1, "R11", "unwrap requests", 128'(unwrap_reqs - ur0), 128'd1);
            chk(!done && !unwrap_req_valid, "R11", "idle after run",
                128'({done, unwrap_req_valid}), 128'd0);
            rdy_always = 1'b1;
        end

        // R10 key never seen outside a decrypt request
        chk(key_leaks == 0, "R10", "key leak cycles", 128'(key_leaks), 128'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule